// File: doc/BRIEF.md
# Flash byte programming sequencer

This block sits on the host side of a command-driven parallel flash device. It programs a run of bytes without help from software. The host hands it address/data pairs over a valid/ready stream and marks the final pair of a run. For each byte the sequencer makes two bus writes: a program-setup command and then the data. It then reads the status register repeatedly, with a fresh output-enable pulse for each read, until the ready bit comes back set. A mode input, sampled with the first byte of a run, picks when the error bits are examined. They can be checked after every byte, or only once the whole run has been written, because the device keeps its error bits set until they are cleared.

When an error bit is found, the sequencer writes the clear-status command, so that the device will accept the next attempt. In per-byte mode it then accepts and discards the rest of the run without any bus activity. Every run ends with the read-array command and a one-cycle done pulse. The pulse carries an error code and the last status byte read. A poll that runs longer than a parameterised number of cycles is abandoned and reported with its own error code.

Top module: `flash_byte_writer`

## Requirements
- R1: Each accepted byte (outside a drained run) produces exactly two bus writes to that byte's address: first 40h, then the data byte.
- R2: For every bus write, chip enable is low and address and data are driven for one cycle before write enable goes low. Write enable is low for exactly one cycle, and address and data are held for one cycle after it. Write enable and output enable are never low together.
- R3: Status is polled with separate read pulses. Output enable is low for two cycles while chip enable is low, and high for at least two cycles between pulses. Polling repeats until status bit 7 reads 1.
- R4: With check_each=1, bits 3 and 4 are examined after every byte. After an error, the remaining bytes of the run are accepted with no bus write until the byte marked last.
- R5: With check_each=0, intermediate bytes wait only for bit 7, and bits 3 and 4 are examined once, on the status read after the last byte.
- R6: run_err encoding: 0 = no error, 1 = voltage low (bit 3; takes priority over bit 4), 2 = program error (bit 4), 3 = poll timeout.
- R7: When bit 3 or bit 4 is found set, the clear-status command 50h is written before the read-array command and before run_done. A later run therefore succeeds.
- R8: Every run ends with FFh written to the address of the run's last byte, followed by run_done.
- R9: If bit 7 is still 0 on a status read completing after POLL_LIMIT or more cycles of polling, polling stops, no 50h is written, and run_err=3.
- R10: run_done is a one-cycle pulse, with run_status equal to the last status byte read. req_ready is high only while no bus cycle is in progress. After reset req_ready=1, all strobes are high and run_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte request valid |
| req_ready | output | 1 | Sequencer can accept a byte |
| req_addr | input | AW | Byte address |
| req_data | input | 8 | Byte value to program |
| req_last | input | 1 | Marks the last byte of a run |
| check_each | input | 1 | 1 = examine error bits per byte, 0 = once per run |
| run_done | output | 1 | One-cycle end-of-run pulse |
| run_err | output | 2 | Error code of the run (see R6) |
| run_status | output | 8 | Last status byte read from the device |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data drivers |
| fl_dq_in | input | 8 | Data read from the flash |

## Verification
A corrupted sequencer state shows up on the flash bus within one bus cycle, about four clocks. It appears as a write out of order (a data write before 40h, or FFh before 50h), or as a write that should not be there during a drain. The scoreboard compares every write pulse in order, so such a fault is flagged at that pulse. A wrong latched mode or error decision does not show on the bus until the end of a run. The device model's faults make it visible there: a missing clear leaves the next run failing, and a wrong code or status appears on the done pulse.

// File: rtl/fbw_pkg.sv
`timescale 1ns/1ps
package fbw_pkg;
    localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
    localparam logic [7:0] CMD_CLEAR      = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int SR_READY = 7;
    localparam int SR_VLOW  = 3;
    localparam int SR_PERR  = 4;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_VLOW    = 2'd1,
        ERR_PROG    = 2'd2,
        ERR_TIMEOUT = 2'd3
    } fbw_err_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } fbw_phase_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT_NEXT, ST_DRAIN, ST_PROG_CMD, ST_PROG_DATA,
        ST_POLL, ST_CHECK, ST_CLEAR, ST_RESTORE, ST_REPORT
    } fbw_state_e;
endpackage

// File: rtl/fbw_bus_cycle.sv
`timescale 1ns/1ps
module fbw_bus_cycle
    import fbw_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in
);
    typedef struct packed {
        fbw_phase_e    ph;
        logic          rd;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic [7:0]    rdata;
    } bus_t;

    bus_t q, n;

    always_comb begin
        n    = q;
        done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    n.ph    = PH_SETUP;
                    n.rd    = is_read;
                    n.addr  = addr;
                    n.wdata = wdata;
                end
            end
            PH_SETUP:  n.ph = PH_STROBE;
            PH_STROBE: begin
                if (q.rd) n.rdata = fl_dq_in;
                n.ph = PH_HOLD;
            end
            PH_HOLD: begin
                done = 1'b1;
                n.ph = PH_IDLE;
            end
            default: n.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, rd: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            q <= n;
        end
    end

    assign fl_ce_n   = (q.ph == PH_IDLE);
    assign fl_we_n   = !((q.ph == PH_STROBE) && !q.rd);
    assign fl_oe_n   = !(q.rd && ((q.ph == PH_SETUP) || (q.ph == PH_STROBE)));
    assign fl_dq_oe  = !q.rd && (q.ph != PH_IDLE);
    assign fl_addr   = q.addr;
    assign fl_dq_out = q.wdata;
    assign rdata     = q.rdata;
endmodule

// File: rtl/fbw_poll_timer.sv
`timescale 1ns/1ps
module fbw_poll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q < LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= LIM);
endmodule

// File: rtl/flash_byte_writer.sv
`timescale 1ns/1ps
module flash_byte_writer
    import fbw_pkg::*;
#(
    parameter int AW         = 17,
    parameter int POLL_LIMIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_last,
    input  logic          check_each,
    output logic          run_done,
    output logic [1:0]    run_err,
    output logic [7:0]    run_status,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in
);
    typedef struct packed {
        fbw_state_e    st;
        logic          issued;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          last;
        logic          each;
        fbw_err_e      err;
        logic [7:0]    status;
    } seq_t;

    seq_t q, n;

    logic       bus_start, bus_rd, bus_done;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tmr_clear, tmr_run, tmr_expired;
    logic       needs_bus;

    fbw_bus_cycle #(.AW(AW)) i_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .is_read  (bus_rd),
        .addr     (q.addr),
        .wdata    (bus_wdata),
        .done     (bus_done),
        .rdata    (bus_rdata),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n),
        .fl_addr  (fl_addr),
        .fl_dq_out(fl_dq_out),
        .fl_dq_oe (fl_dq_oe),
        .fl_dq_in (fl_dq_in)
    );

    fbw_poll_timer #(.LIMIT(POLL_LIMIT)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    always_comb begin
        n         = q;
        req_ready = 1'b0;
        run_done  = 1'b0;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        bus_rd    = (q.st == ST_POLL);
        needs_bus = (q.st == ST_PROG_CMD) || (q.st == ST_PROG_DATA) ||
                    (q.st == ST_POLL) || (q.st == ST_CLEAR) || (q.st == ST_RESTORE);
        case (q.st)
            ST_PROG_DATA: bus_wdata = q.data;
            ST_CLEAR:     bus_wdata = CMD_CLEAR;
            ST_RESTORE:   bus_wdata = CMD_READ_ARRAY;
            default:      bus_wdata = CMD_PROG_SETUP;
        endcase
        bus_start = needs_bus && !q.issued;
        if (bus_start)     n.issued = 1'b1;
        else if (bus_done) n.issued = 1'b0;

        case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    n.addr   = req_addr;
                    n.data   = req_data;
                    n.last   = req_last;
                    n.each   = check_each;
                    n.err    = ERR_NONE;
                    n.status = '0;
                    n.st     = ST_PROG_CMD;
                end
            end
            ST_WAIT_NEXT: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    n.addr = req_addr;
                    n.data = req_data;
                    n.last = req_last;
                    n.st   = ST_PROG_CMD;
                end
            end
            ST_DRAIN: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    n.addr = req_addr;
                    n.last = req_last;
                    if (req_last) n.st = ST_RESTORE;
                end
            end
            ST_PROG_CMD: begin
                if (bus_done) n.st = ST_PROG_DATA;
            end
            ST_PROG_DATA: begin
                if (bus_done) begin
                    n.st      = ST_POLL;
                    tmr_clear = 1'b1;
                end
            end
            ST_POLL: begin
                tmr_run = 1'b1;
                if (bus_done) begin
                    n.status = bus_rdata;
                    if (bus_rdata[SR_READY]) begin
                        n.st = (q.each || q.last) ? ST_CHECK : ST_WAIT_NEXT;
                    end else if (tmr_expired) begin
                        n.err = ERR_TIMEOUT;
                        n.st  = q.last ? ST_RESTORE : ST_DRAIN;
                    end
                end
            end
            ST_CHECK: begin
                if (q.status[SR_VLOW]) begin
                    n.err = ERR_VLOW;
                    n.st  = ST_CLEAR;
                end else if (q.status[SR_PERR]) begin
                    n.err = ERR_PROG;
                    n.st  = ST_CLEAR;
                end else begin
                    n.st  = q.last ? ST_RESTORE : ST_WAIT_NEXT;
                end
            end
            ST_CLEAR: begin
                if (bus_done) n.st = q.last ? ST_RESTORE : ST_DRAIN;
            end
            ST_RESTORE: begin
                if (bus_done) n.st = ST_REPORT;
            end
            ST_REPORT: begin
                run_done = 1'b1;
                n.st     = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, issued: 1'b0, addr: '0, data: '0, last: 1'b0,
                   each: 1'b0, err: ERR_NONE, status: '0};
        end else begin
            q <= n;
        end
    end

    assign run_err    = q.err;
    assign run_status = q.status;
endmodule

// File: rtl/fbw_checker.sv
`timescale 1ns/1ps
module fbw_checker #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_out,
    input logic          fl_dq_oe,
    input logic          run_done,
    input logic          req_ready
);
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n);

    a_r2_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe && !fl_ce_n));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe && !fl_ce_n));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_oe_n);

    a_r3_oe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_ce_n && !fl_dq_oe));

    a_r3_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_oe_n) |=> fl_oe_n);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done);

    a_r10_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_ce_n);
endmodule

bind flash_byte_writer fbw_checker #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n),
    .fl_addr  (fl_addr),
    .fl_dq_out(fl_dq_out),
    .fl_dq_oe (fl_dq_oe),
    .run_done (run_done),
    .req_ready(req_ready)
);

// File: tb/test_flash_byte_writer.sv
`timescale 1ns/1ps
module test_flash_byte_writer;
    localparam int AW    = 17;
    localparam int LIMIT = 64;
    localparam int BUSY  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_last = 1'b0;
    logic          check_each = 1'b0;
    logic          run_done;
    logic [1:0]    run_err;
    logic [7:0]    run_status;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;

    always #2.5 clk = ~clk;

    flash_byte_writer #(.AW(AW), .POLL_LIMIT(LIMIT)) i_flash_byte_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
        .check_each(check_each), .run_done(run_done), .run_err(run_err),
        .run_status(run_status), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    // Behavioural device model; fault kind 1 = program error, 2 = low voltage, 3 = stuck busy
    int         fault_kind = 0;
    logic [7:0] fault_data = 8'h00;
    logic       release_hang = 1'b0;
    logic       dev_pend, dev_stat_mode, dev_hang;
    int         dev_busy;
    logic [7:0] dev_sr;

    assign fl_dq_in = (!fl_oe_n && !fl_ce_n)
                    ? (dev_stat_mode ? {(dev_busy == 0) && !dev_hang, dev_sr[6:0]} : 8'hA5)
                    : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            dev_pend <= 1'b0; dev_stat_mode <= 1'b0; dev_hang <= 1'b0;
            dev_busy <= 0; dev_sr <= 8'h00;
        end else begin
            if (release_hang) begin
                dev_hang <= 1'b0; dev_busy <= 0;
            end else if (dev_busy != 0 && !dev_hang) begin
                dev_busy <= dev_busy - 1;
            end
            if (!fl_we_n && !fl_ce_n) begin
                if (dev_pend) begin
                    dev_pend <= 1'b0;
                    dev_stat_mode <= 1'b1;
                    if (dev_sr[3]) begin
                        dev_busy <= 0;
                    end else if (fault_kind == 2 && fl_dq_out == fault_data) begin
                        dev_sr <= dev_sr | 8'h18;
                    end else begin
                        dev_busy <= BUSY;
                        if (fault_kind == 1 && fl_dq_out == fault_data) dev_sr <= dev_sr | 8'h10;
                        if (fault_kind == 3 && fl_dq_out == fault_data) dev_hang <= 1'b1;
                    end
                end else begin
                    case (fl_dq_out)
                        8'h40: begin dev_pend <= 1'b1; dev_stat_mode <= 1'b1; end
                        8'h50: dev_sr <= dev_sr & 8'hE7;
                        8'hFF: dev_stat_mode <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Scoreboard
    logic [AW+7:0] exp_wr[$];
    logic [9:0]    exp_res[$];
    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int rd_count = 0;
    logic oe_prev = 1'b1;

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog R10: actual hung run, expected completion");
            finish_run();
        end
        if (rst_n) begin
            if (!fl_oe_n && oe_prev) rd_count++;
            oe_prev = fl_oe_n;
            if (!fl_we_n) begin
                tests++;
                if (exp_wr.size() == 0) begin
                    fails++;
                    $display("FAIL R1/R4/R7/R8 write: actual %h:%h expected none", fl_addr, fl_dq_out);
                end else begin
                    logic [AW+7:0] e;
                    e = exp_wr.pop_front();
                    if (e !== {fl_addr, fl_dq_out}) begin
                        fails++;
                        $display("FAIL R1/R4/R5/R7/R8 write: actual %h:%h expected %h:%h",
                                 fl_addr, fl_dq_out, e[AW+7:8], e[7:0]);
                    end
                end
            end
            if (run_done) begin
                tests++;
                if (exp_res.size() == 0 || exp_wr.size() != 0) begin
                    fails++;
                    $display("FAIL R8/R10 done: actual %0d/%h expected results=%0d pending writes=%0d",
                             run_err, run_status, exp_res.size(), exp_wr.size());
                end else begin
                    logic [9:0] r;
                    r = exp_res.pop_front();
                    if (r !== {run_err, run_status}) begin
                        fails++;
                        $display("FAIL R6/R9/R10 result: actual %0d/%h expected %0d/%h",
                                 run_err, run_status, r[9:8], r[7:0]);
                    end
                end
            end
        end
    end

    task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d);
        exp_wr.push_back({a, d});
    endtask

    // n bytes from base; fk/fidx select an injected fault on byte fidx
    task automatic run(input int n, input bit each, input int fk, input int fidx,
                       input logic [AW-1:0] base);
        logic [AW-1:0] last_a;
        logic [1:0]    err;
        logic [7:0]    st;
        bit            stop;
        last_a = base + AW'(n - 1);
        err = 2'd0; st = 8'h80; stop = 0;
        for (int i = 0; i < n && !stop; i++) begin
            push_wr(base + AW'(i), 8'h40);
            push_wr(base + AW'(i), 8'h30 + 8'(i));
            if (fk != 0 && i == fidx) begin
                if (fk == 3) begin err = 2'd3; st = 8'h00; stop = 1; end
                else if (each) begin
                    push_wr(base + AW'(i), 8'h50);
                    err = (fk == 2) ? 2'd1 : 2'd2;
                    st  = (fk == 2) ? 8'h98 : 8'h90;
                    stop = 1;
                end
            end
        end
        if (!each && (fk == 1 || fk == 2)) begin
            push_wr(last_a, 8'h50);
            err = (fk == 2) ? 2'd1 : 2'd2;
            st  = (fk == 2) ? 8'h98 : 8'h90;
        end
        push_wr(last_a, 8'hFF);
        exp_res.push_back({err, st});

        fault_kind = fk;
        fault_data = 8'h30 + 8'(fidx);
        rd_count = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid  = 1'b1;
            req_addr   = base + AW'(i);
            req_data   = 8'h30 + 8'(i);
            req_last   = (i == n - 1);
            check_each = each;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_res.size() != 0) @(negedge clk);
        fault_kind = 0;
        release_hang = 1'b1;
        @(negedge clk);
        release_hang = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (!(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !run_done)) begin
            fails++;
            $display("FAIL R10 reset: actual rdy=%b ce=%b we=%b oe=%b done=%b expected 1,1,1,1,0",
                     req_ready, fl_ce_n, fl_we_n, fl_oe_n, run_done);
        end
        run(1, 1'b1, 0, 0, 17'h00100);                 // R1 R8 single byte
        tests++;
        if (rd_count < 2) begin                        // R3 repeated polling while busy
            fails++;
            $display("FAIL R3 polls: actual %0d expected >=2", rd_count);
        end
        run(4, 1'b1, 0, 0, 17'h1FFF0);                 // R4 per-byte, clean
        run(4, 1'b0, 0, 0, 17'h02000);                 // R5 deferred, clean
        run(3, 1'b1, 1, 1, 17'h03000);                 // R4 R6 R7 program error, drain
        run(3, 1'b0, 1, 0, 17'h04000);                 // R5 R7 sticky bit at run end
        run(3, 1'b1, 2, 0, 17'h05000);                 // R6 low voltage priority
        run(2, 1'b1, 0, 0, 17'h05800);                 // R7 clear allowed the retry
        run(2, 1'b0, 2, 1, 17'h06000);                 // R5 R6 deferred low voltage
        run(2, 1'b1, 0, 0, 17'h06800);                 // R7 recovery
        run(2, 1'b1, 3, 0, 17'h07000);                 // R9 timeout, drain
        tests++;
        if (rd_count < 2) begin                        // R3 R9 kept polling until the limit
            fails++;
            $display("FAIL R3/R9 polls: actual %0d expected >=2", rd_count);
        end
        run(3, 1'b0, 3, 1, 17'h08000);                 // R9 deferred timeout
        run(1, 1'b0, 0, 0, 17'h00000);                 // R8 after timeout
        finish_run();
    end
endmodule